// File: doc/BRIEF.md
# Intra 4x4 Luma Sample Predictor

This block forms a 4x4 tile of predicted 8-bit luma samples from the thirteen reconstructed samples that border it. These are the corner sample above-left of the tile, a row of eight samples above it (four directly over the tile and four further right), and a column of four samples to its left. A 4-bit mode number picks one of nine predictions at run time. Two copy the border straight across the tile, one fills the tile with a rounded mean, and six interpolate along diagonal directions.

A request made of the border samples and the mode enters through a valid/ready handshake. The whole 16-sample tile comes out two cycles later as one wide word with a valid flag, and the sink may hold it back. Every border sample is taken as present, so substitution for missing neighbours is left to the caller. All directional modes share one bank of 2-tap and 3-tap rounding filters placed along a single 13-entry edge vector. Each output cell then selects one filter output through a per-mode mapping.

Top module: `intra4x4_pred`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. If `in_ready` stays 1 on the edge that follows, the result is presented (`out_valid`=1) two cycles after the accepting cycle. Results leave in acceptance order.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_pix` and `out_err` hold their values and `out_valid` stays 1.
- R4: Layout and mode 0 (vertical). Top sample Tk is `in_top[8k+:8]`, left sample Lk is `in_left[8k+:8]`, and cell (row r, column c) is `out_pix[8*(4r+c)+:8]`. In mode 0, every cell in column c equals Tc.
- R5: In mode 1 (horizontal), every cell in row r equals Lr.
- R6: In mode 2 (DC), all cells equal (T0+T1+T2+T3+L0+L1+L2+L3+4)>>3. The corner sample and T4..T7 have no effect, so tops of 1 and lefts of 3 give 2 whatever they hold.
- R7: The 2-tap filter is (a+b+1)>>1 and the 3-tap filter is (a+2b+c+2)>>2. When all 13 border samples hold one value, every mode from 0 to 8 outputs that value in all 16 cells.
- R8: Mode 3 (diagonal down-left) gives cell (r,c) = 3-tap(T[r+c], T[r+c+1], T[r+c+2]), except cell (3,3), which is (T6+3*T7+2)>>2. Mode 7 (vertical-left) gives the 2-tap of T[c+r/2], T[c+r/2+1] on even rows and the 3-tap centred on T[c+(r-1)/2+1] on odd rows. Only modes 3 and 7 depend on T4..T7.
- R9: Mode 4 (diagonal down-right) and mode 6 (horizontal-down) follow the standard diagonal index mappings. Mode 4 puts the 3-tap centred on the corner sample on its main diagonal. In mode 6, cell (r,c) with 2r-c even and non-negative is the 2-tap of L[r-c/2-1] and L[r-c/2], where L[-1] means the corner sample.
- R10: Mode 5 (vertical-right). Row 0 holds the 2-tap of the adjacent pairs (corner,T0) through (T2,T3). Row 1 holds the 3-tap centred on the corner, then on T0, T1 and T2. Cell (2,0) is the 3-tap centred on L0, and cell (3,0) is the 3-tap centred on L1. In rows 2 and 3, columns 1..3 repeat the row two above, moved one column right. With corner 5, T0..T3 = 10,20,30,40 and L0..L2 = 50,60,70, the rows are {8,15,25,35}, {18,11,20,30}, {41,8,15,25}, {60,18,11,20}.
- R11: Mode 8 (horizontal-up) indexes cells by z = c+2r. Even z<5 gives a 2-tap and odd z<5 gives a 3-tap, both taken down the left column. z=5 gives (L2+3*L3+2)>>2, and every z>5 equals L3.
- R12: `out_err` is 1 exactly for mode codes 9..15, and for those codes `out_pix` carries the DC result of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_mode | input | 4 | Prediction mode, 0..8 valid |
| in_tl | input | 8 | Sample above-left of the tile |
| in_top | input | 64 | T0..T7, T0 in the low byte |
| in_left | input | 32 | L0..L3, L0 in the low byte |
| out_valid | output | 1 | Tile result present |
| out_ready | input | 1 | Sink takes the result this cycle |
| out_pix | output | 128 | 16 samples in raster order, cell (0,0) in the low byte |
| out_err | output | 1 | Mode code was outside 0..8 |

## Verification
The bench aims first at orientation. It uses a lopsided vertical-right context where swapping rows and columns, or shifting the repeated rows the wrong way, breaks most of the 16 cells. It also probes the clamped ends of the edge vector: cell (3,3) of diagonal down-left and cell z=5 of horizontal-up. A filter bank that did not clamp its end taps would read a neighbour from beyond the edge vector and corrupt exactly those cells. DC is fed a corner sample and above-right samples that must not leak into the mean, and the out-of-range codes must raise the flag while still yielding the DC tile. Random back-pressure checks that a stalled result stays frozen and that a queued request is neither lost nor duplicated.

// File: rtl/intra4_pkg.sv
package intra4_pkg;

  localparam int BLK     = 4;
  localparam int N_TOP   = 2 * BLK;
  localparam int N_EDGE  = N_TOP + BLK + 1;
  localparam int N_CELL  = BLK * BLK;
  localparam int MODE_W  = 4;
  localparam int N_MODES = 9;
  localparam int IDX_W   = $clog2(N_EDGE);
  // Positions on the edge vector: L3..L0, corner, T0..T7.
  localparam int L0_POS  = BLK - 1;
  localparam int TL_POS  = BLK;
  localparam int T0_POS  = BLK + 1;

  typedef enum logic [MODE_W-1:0] {
    M_VERT = 4'd0, M_HORZ = 4'd1, M_DC  = 4'd2, M_DDL = 4'd3, M_DDR = 4'd4,
    M_VR   = 4'd5, M_HD   = 4'd6, M_VL  = 4'd7, M_HU  = 4'd8
  } mode_e;

  typedef enum logic [1:0] {SRC_EDGE, SRC_F2, SRC_F3, SRC_DC} src_e;

  typedef struct packed {
    src_e             src;
    logic [IDX_W-1:0] idx;
  } tap_t;

  // Which filter output (or raw edge sample) feeds cell (r,c) in a mode.
  // F2 index i filters edge[i] and edge[i+1]; F3 index i is centred on edge[i].
  function automatic tap_t tap_of(input logic [MODE_W-1:0] mode, input int r, input int c);
    tap_t t;
    int   k;
    int   z;
    t.src = SRC_DC;
    k     = 0;
    case (mode)
      M_VERT: begin t.src = SRC_EDGE; k = T0_POS + c; end
      M_HORZ: begin t.src = SRC_EDGE; k = L0_POS - r; end
      M_DDL:  begin t.src = SRC_F3;   k = T0_POS + 1 + r + c; end
      M_DDR:  begin t.src = SRC_F3;   k = TL_POS + c - r; end
      M_VR: begin
        z = 2 * c - r;
        if (z >= 0) begin
          t.src = ((z & 1) == 0) ? SRC_F2 : SRC_F3;
          k     = TL_POS + c - (r >> 1);
        end else if (z == -1) begin
          t.src = SRC_F3; k = TL_POS;
        end else begin
          t.src = SRC_F3; k = TL_POS + 1 - r;
        end
      end
      M_HD: begin
        z = 2 * r - c;
        if (z >= 0) begin
          if ((z & 1) == 0) begin t.src = SRC_F2; k = L0_POS - r + (c >> 1); end
          else              begin t.src = SRC_F3; k = TL_POS - r + (c >> 1); end
        end else if (z == -1) begin
          t.src = SRC_F3; k = TL_POS;
        end else begin
          t.src = SRC_F3; k = L0_POS + c;
        end
      end
      M_VL: begin
        if ((r & 1) == 0) begin t.src = SRC_F2; k = T0_POS + c + (r >> 1); end
        else              begin t.src = SRC_F3; k = T0_POS + 1 + c + (r >> 1); end
      end
      M_HU: begin
        z = c + 2 * r;
        if (z > 5) begin
          t.src = SRC_EDGE; k = 0;
        end else begin
          t.src = ((z & 1) == 0) ? SRC_F2 : SRC_F3;
          k     = L0_POS - 1 - (r + (c >> 1));
        end
      end
      default: begin t.src = SRC_DC; k = 0; end
    endcase
    t.idx = IDX_W'(k);
    return t;
  endfunction

endpackage

// File: rtl/intra4_filters.sv
module intra4_filters import intra4_pkg::*; #(
  parameter int W = 8
) (
  input  logic [W-1:0] edge_s [N_EDGE],
  output logic [W-1:0] f2     [N_EDGE],
  output logic [W-1:0] f3     [N_EDGE]
);
  // One 2-tap and one 3-tap per edge position; the ends clamp to the last sample.
  for (genvar i = 0; i < N_EDGE; i++) begin : g_tap
    localparam int LO = (i == 0) ? 0 : i - 1;
    localparam int HI = (i == N_EDGE - 1) ? i : i + 1;
    logic [W:0]   sum2;
    logic [W+1:0] sum3;
    always_comb begin
      sum2  = {1'b0, edge_s[i]} + {1'b0, edge_s[HI]} + (W+1)'(1);
      sum3  = {2'b00, edge_s[LO]} + {1'b0, edge_s[i], 1'b0} + {2'b00, edge_s[HI]} + (W+2)'(2);
      f2[i] = sum2[W:1];
      f3[i] = sum3[W+1:2];
    end
  end
endmodule

// File: rtl/intra4_dc.sv
module intra4_dc import intra4_pkg::*; #(
  parameter int W = 8
) (
  input  logic [W-1:0] edge_s [N_EDGE],
  output logic [W-1:0] dc
);
  localparam int SH    = $clog2(2 * BLK);
  localparam int SUM_W = W + SH;

  logic [SUM_W-1:0] acc;
  always_comb begin
    acc = SUM_W'(BLK);
    for (int k = 0; k < BLK; k++) begin
      acc = acc + SUM_W'(edge_s[T0_POS + k]) + SUM_W'(edge_s[L0_POS - k]);
    end
    dc = acc[SUM_W-1:SH];
  end
endmodule

// File: rtl/intra4_cell.sv
module intra4_cell import intra4_pkg::*; #(
  parameter int W   = 8,
  parameter int ROW = 0,
  parameter int COL = 0
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [W-1:0]      edge_s [N_EDGE],
  input  logic [W-1:0]      f2     [N_EDGE],
  input  logic [W-1:0]      f3     [N_EDGE],
  input  logic [W-1:0]      dc,
  output logic [W-1:0]      pix
);
  tap_t tap;
  logic in_range;

  always_comb begin
    tap      = tap_of(mode, ROW, COL);
    in_range = (int'(tap.idx) < N_EDGE);
    pix      = dc;
    if (in_range) begin
      case (tap.src)
        SRC_EDGE: pix = edge_s[tap.idx];
        SRC_F2:   pix = f2[tap.idx];
        SRC_F3:   pix = f3[tap.idx];
        default:  pix = dc;
      endcase
    end
  end
endmodule

// File: rtl/intra4x4_pred.sv
module intra4x4_pred import intra4_pkg::*; #(
  parameter int SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [MODE_W-1:0]          in_mode,
  input  logic [SAMPLE_W-1:0]        in_tl,
  input  logic [N_TOP*SAMPLE_W-1:0]  in_top,
  input  logic [BLK*SAMPLE_W-1:0]    in_left,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [N_CELL*SAMPLE_W-1:0] out_pix,
  output logic                       out_err
);
  localparam int W = SAMPLE_W;

  logic [W-1:0] edge_in [N_EDGE];
  logic [W-1:0] s1_edge [N_EDGE];
  logic [W-1:0] f2      [N_EDGE];
  logic [W-1:0] f3      [N_EDGE];
  logic [W-1:0] dc;
  logic [W-1:0] cell_pix [N_CELL];
  logic [N_CELL*W-1:0] cell_bus;
  logic [MODE_W-1:0]   s1_mode;
  logic                s1_valid;
  logic                advance;

  // Flatten the border into one vector ordered L3..L0, corner, T0..T7.
  always_comb begin
    edge_in[TL_POS] = in_tl;
    for (int k = 0; k < BLK; k++)   edge_in[L0_POS - k] = in_left[k*W +: W];
    for (int k = 0; k < N_TOP; k++) edge_in[T0_POS + k] = in_top[k*W +: W];
  end

  assign in_ready = !out_valid || out_ready;
  assign advance  = in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else if (advance) begin
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      if (in_valid) begin
        s1_mode <= in_mode;
        s1_edge <= edge_in;
      end
      if (s1_valid) begin
        out_pix <= cell_bus;
        out_err <= (int'(s1_mode) >= N_MODES);
      end
    end
  end

  intra4_filters #(.W(W)) u_filters (
    .edge_s (s1_edge),
    .f2     (f2),
    .f3     (f3)
  );

  intra4_dc #(.W(W)) u_dc (
    .edge_s (s1_edge),
    .dc     (dc)
  );

  for (genvar r = 0; r < BLK; r++) begin : g_row
    for (genvar c = 0; c < BLK; c++) begin : g_col
      intra4_cell #(.W(W), .ROW(r), .COL(c)) u_cell (
        .mode   (s1_mode),
        .edge_s (s1_edge),
        .f2     (f2),
        .f3     (f3),
        .dc     (dc),
        .pix    (cell_pix[r*BLK + c])
      );
      assign cell_bus[(r*BLK + c)*W +: W] = cell_pix[r*BLK + c];
    end
  end
endmodule

// File: rtl/intra4_checker.sv
module intra4_checker import intra4_pkg::*; #(
  parameter int W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [MODE_W-1:0]    in_mode,
  input logic [N_TOP*W-1:0]   in_top,
  input logic [BLK*W-1:0]     in_left,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [N_CELL*W-1:0]  out_pix,
  input logic                 out_err
);
  function automatic logic [N_CELL*W-1:0] rows_of(input logic [BLK*W-1:0] l);
    logic [N_CELL*W-1:0] v;
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++)
        v[(r*BLK + c)*W +: W] = l[r*W +: W];
    return v;
  endfunction

  logic took;
  assign took = in_valid && in_ready;

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready));

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(took, 2) && $past(in_ready, 1)) |-> out_valid);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_err)));

  p_vertical_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(took && in_mode == 4'd0, 2) && $past(in_ready, 1))
      |-> out_pix == {BLK{$past(in_top[BLK*W-1:0], 2)}});

  p_horizontal_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(took && in_mode == 4'd1, 2) && $past(in_ready, 1))
      |-> out_pix == rows_of($past(in_left, 2)));

  p_err_flag_r12: assert property (@(posedge clk) disable iff (rst)
    ($past(took, 2) && $past(in_ready, 1))
      |-> out_err == (int'($past(in_mode, 2)) >= N_MODES));

  p_err_flat_r12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> out_pix == {N_CELL{out_pix[W-1:0]}});
endmodule

bind intra4x4_pred intra4_checker #(.W(SAMPLE_W)) u_chk (.*);

// File: tb/tb_intra4x4_pred.sv
module tb_intra4x4_pred;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [3:0]   in_mode = '0;
  logic [7:0]   in_tl = '0;
  logic [63:0]  in_top = '0;
  logic [31:0]  in_left = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_pix;
  logic         out_err;

  always #10 clk = ~clk;

  intra4x4_pred dut (.*);

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int stall_cnt = 0;
  bit finished = 0;

  typedef struct {
    logic [127:0] pix;
    logic         err;
    int           tag;
    int           acc;
    int           stl;
  } item_t;
  item_t q[$];
  bit presented = 0;
  logic [127:0] last_pix;
  logic         last_err;
  int uniform_tag = 0;

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic int tag_of_mode(input int m);
    case (m)
      0: return 4; 1: return 5; 2: return 6; 3: return 8; 7: return 8;
      4: return 9; 6: return 9; 5: return 10; 8: return 11;
      default: return 12;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: border sample at (x,y), x=-1 is the left column, y=-1 the top row.
  int m_tl;
  int m_t[8];
  int m_l[4];
  function automatic int P(input int x, input int y);
    if (x == -1 && y == -1) return m_tl;
    if (y == -1) return m_t[x];
    return m_l[y];
  endfunction
  function automatic int a3(input int a, input int b, input int c);
    return (a + 2*b + c + 2) >> 2;
  endfunction
  function automatic int a2(input int a, input int b);
    return (a + b + 1) >> 1;
  endfunction

  function automatic logic [127:0] model(input int mode);
    logic [127:0] v;
    int s, z, d;
    s = 4;
    for (int k = 0; k < 4; k++) s += m_t[k] + m_l[k];
    for (int y = 0; y < 4; y++) begin
      for (int x = 0; x < 4; x++) begin
        case (mode)
          0: d = P(x, -1);
          1: d = P(-1, y);
          3: d = (x == 3 && y == 3) ? (P(6,-1) + 3*P(7,-1) + 2) >> 2
                                     : a3(P(x+y,-1), P(x+y+1,-1), P(x+y+2,-1));
          4: if (x > y)      d = a3(P(x-y-2,-1), P(x-y-1,-1), P(x-y,-1));
             else if (x < y) d = a3(P(-1,y-x-2), P(-1,y-x-1), P(-1,y-x));
             else            d = a3(P(0,-1), P(-1,-1), P(-1,0));
          5: begin
            z = 2*x - y;
            if (z >= 0 && (z % 2) == 0) d = a2(P(x-(y>>1)-1,-1), P(x-(y>>1),-1));
            else if (z > 0)  d = a3(P(x-(y>>1)-2,-1), P(x-(y>>1)-1,-1), P(x-(y>>1),-1));
            else if (z == -1) d = a3(P(-1,0), P(-1,-1), P(0,-1));
            else d = a3(P(-1,y-1), P(-1,y-2), P(-1,y-3));
          end
          6: begin
            z = 2*y - x;
            if (z >= 0 && (z % 2) == 0) d = a2(P(-1,y-(x>>1)-1), P(-1,y-(x>>1)));
            else if (z > 0)  d = a3(P(-1,y-(x>>1)-2), P(-1,y-(x>>1)-1), P(-1,y-(x>>1)));
            else if (z == -1) d = a3(P(-1,0), P(-1,-1), P(0,-1));
            else d = a3(P(x-1,-1), P(x-2,-1), P(x-3,-1));
          end
          7: if ((y % 2) == 0) d = a2(P(x+(y>>1),-1), P(x+(y>>1)+1,-1));
             else d = a3(P(x+(y>>1),-1), P(x+(y>>1)+1,-1), P(x+(y>>1)+2,-1));
          8: begin
            z = x + 2*y;
            if (z > 5)       d = P(-1,3);
            else if (z == 5) d = (P(-1,2) + 3*P(-1,3) + 2) >> 2;
            else if ((z % 2) == 0) d = a2(P(-1,y+(x>>1)), P(-1,y+(x>>1)+1));
            else d = a3(P(-1,y+(x>>1)), P(-1,y+(x>>1)+1), P(-1,y+(x>>1)+2));
          end
          default: d = s >> 3;
        endcase
        v[(y*4+x)*8 +: 8] = 8'(d);
      end
    end
    return v;
  endfunction

  // Cycle monitor: checks handshake, timing and every presented result.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(in_ready == (!out_valid || out_ready), "R2", {127'd0, in_ready}, {127'd0, (!out_valid || out_ready)});
      if (out_valid && !out_ready) stall_cnt++;
      if (out_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2", out_pix, '0);
        end else begin
          if (!presented && q[0].stl == stall_cnt - ((!out_ready) ? 1 : 0))
            chk((cyc - q[0].acc) == 2, "R2", 128'(cyc - q[0].acc), 128'd2);
          chk(out_pix == q[0].pix, presented ? "R3" : tag_name(q[0].tag), out_pix, q[0].pix);
          chk(out_err == q[0].err, presented ? "R3" : "R12", {127'd0, out_err}, {127'd0, q[0].err});
          presented = 1;
          if (out_ready) begin
            last_pix = out_pix;
            last_err = out_err;
            void'(q.pop_front());
            presented = 0;
          end
        end
      end
      if (in_valid && in_ready) begin
        item_t it;
        m_tl = in_tl;
        for (int k = 0; k < 8; k++) m_t[k] = in_top[k*8 +: 8];
        for (int k = 0; k < 4; k++) m_l[k] = in_left[k*8 +: 8];
        it.pix = model(in_mode);
        it.err = (in_mode > 4'd8);
        it.tag = (uniform_tag != 0) ? uniform_tag : tag_of_mode(in_mode);
        it.acc = cyc;
        it.stl = stall_cnt;
        q.push_back(it);
      end
    end
  end

  task automatic send(input int mode, input int tl, input logic [63:0] top, input logic [31:0] left);
    in_valid = 1'b1;
    in_mode  = 4'(mode);
    in_tl    = 8'(tl);
    in_top   = top;
    in_left  = left;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) begin
      @(posedge clk);
      #1;
    end
  endtask

  function automatic logic [127:0] rows4(input int a0, a1, a2_, a3_, b0, b1, b2, b3,
                                        c0, c1, c2, c3, d0, d1, d2, d3);
    return {8'(d3), 8'(d2), 8'(d1), 8'(d0), 8'(c3), 8'(c2), 8'(c1), 8'(c0),
            8'(b3), 8'(b2), 8'(b1), 8'(b0), 8'(a3_), 8'(a2_), 8'(a1), 8'(a0)};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: state while in reset
    chk(!out_valid && in_ready, "R1", {126'd0, out_valid, in_ready}, 128'd1);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1", {126'd0, out_valid, in_ready}, 128'd1);
    @(posedge clk);
    #1;

    // R7: uniform contexts reproduce the value in every mode
    uniform_tag = 7;
    for (int m = 0; m < 9; m++) begin
      int v;
      v = 17 + 25 * m;
      send(m, v, {8{8'(v)}}, {4{8'(v)}});
    end
    drain();
    uniform_tag = 0;

    // R10: lopsided vertical-right context, explicit expected tile
    send(5, 5, {32'd0, 8'd40, 8'd30, 8'd20, 8'd10}, {8'd0, 8'd70, 8'd60, 8'd50});
    drain();
    chk(last_pix == rows4(8,15,25,35, 18,11,20,30, 41,8,15,25, 60,18,11,20), "R10",
        last_pix, rows4(8,15,25,35, 18,11,20,30, 41,8,15,25, 60,18,11,20));

    // R6: DC ignores the corner and the above-right samples
    send(2, 99, {32'hFFFF_FFFF, 32'h0101_0101}, 32'h0303_0303);
    drain();
    chk(last_pix == {16{8'd2}}, "R6", last_pix, {16{8'd2}});
    chk(last_err == 1'b0, "R12", {127'd0, last_err}, 128'd0);

    // R4, R5: straight copies with distinct samples
    send(0, 1, 64'hF0E0_D0C0_4030_2010, 32'h8070_6050);
    send(1, 1, 64'hF0E0_D0C0_4030_2010, 32'h8070_6050);
    drain();

    // R8: diagonal-left corner cell with a steep above-right ramp
    send(3, 0, 64'hFF00_8040_2010_0804, 32'h0);
    drain();
    chk(last_pix[127:120] == 8'((8'h00 + 3*8'hFF + 2) >> 2), "R8",
        128'(last_pix[127:120]), 128'((0 + 3*255 + 2) >> 2));
    send(7, 0, 64'hFF00_8040_2010_0804, 32'h0);

    // R9: down-right and horizontal-down on a gradient
    send(4, 128, 64'h0000_0000_C8A0_7850, 32'h0A28_4664);
    send(6, 128, 64'h0000_0000_C8A0_7850, 32'h0A28_4664);
    drain();

    // R11: horizontal-up saturation and the z=5 cell
    send(8, 0, 64'h0, 32'hFF00_8040);
    drain();
    chk(last_pix[8*9 +: 8] == 8'((0 + 3*255 + 2) >> 2), "R11",
        128'(last_pix[8*9 +: 8]), 128'((0 + 3*255 + 2) >> 2));
    chk(last_pix[127:120] == 8'hFF, "R11", 128'(last_pix[127:120]), 128'hFF);

    // R12: out-of-range mode codes
    for (int m = 9; m < 16; m++) send(m, 7, 64'h0102_0304_0A14_1E28, 32'h3C32_4650);
    drain();

    // R3: stall with one result waiting and one queued behind it
    out_ready = 1'b0;
    send(5, 33, 64'h1122_3344_5566_7788, 32'h99AA_BBCC);
    send(6, 44, 64'h0F1E_2D3C_4B5A_6978, 32'h8796_A5B4);
    repeat (6) begin @(posedge clk); #1; end
    chk(out_valid && !in_ready, "R3", {126'd0, out_valid, in_ready}, 128'd2);
    out_ready = 1'b1;
    drain();

    // Random traffic with random back-pressure
    begin
      bit sent_all;
      sent_all = 0;
      fork
        begin
          for (int n = 0; n < 200; n++)
            send($urandom % 16, $urandom % 256, {$urandom, $urandom}, $urandom);
          sent_all = 1;
        end
        begin
          while (!sent_all) begin
            @(posedge clk);
            #1;
            out_ready = (($urandom % 4) != 0);
          end
        end
      join
    end
    out_ready = 1'b1;
    drain();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule